// File: doc/BRIEF.md
# Multi-core time base synchronizer

This block keeps one time base counter per processor core and holds all of them in step. One shared tick-enable input advances every counter together. Firmware uses a broadcast load command to write one common value into every counter in the same clock cycle. It uses this at start-up, and whenever it wants to realign the whole machine.

A single core can also lose its time base state. For example, it may have been powered down. Such a core is flagged through its own lost input. Its counter contents are then discarded and its valid flag drops. While a core is invalid, its read port returns the value of a fixed reference core, so no reader ever sees a stale or zeroed time. A resync command names one target core. The target then takes the reference core's next value and becomes valid again, and no other counter is touched. Every read port has the same registered latency. As a result, all ports show the same time in any cycle, and that time never decreases between loads.

Top module: `tbsync_top`

## Requirements
- R1: While the synchronous reset is high, every counter clears to zero and every core is marked valid. In the first cycle after reset, every read port shows zero and `core_valid` is all ones.
- R2: On each cycle with `tick_en` high and no load, every valid counter increments by one, wrapping from all ones to zero. With `tick_en` low, counters hold.
- R3: `load_cmd` writes `load_val` into every counter in the same cycle and marks every core valid. The tick of that cycle is not added. A load takes priority over any lost or resync request in the same cycle.
- R4: A high bit `lost[i]` for a core other than the reference core clears that core's valid flag and discards its counter. The lost bit of the reference core (index `REF_CORE`, default 0) has no effect.
- R5: The read port of an invalid core returns the reference core's value.
- R6: `resync_cmd` with target index `resync_tgt` loads the target counter with the reference value plus that cycle's tick, and sets its valid flag. No other core changes. Resync takes priority over lost for the same core. A resync aimed at the reference core has no effect.
- R7: Read port `i` is `rd_val[i*TW +: TW]`. It shows, one clock later, the counter value held before the edge, with identical latency on every port. `core_valid` is the flag register itself.
- R8: In every cycle all read ports show the same value. Apart from a load or a wrap, that value never decreases from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole block |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Shared advance enable for all counters |
| load_cmd | input | 1 | Broadcast load strobe |
| load_val | input | TW | Value written by a broadcast load |
| lost | input | NCORE | Per-core state-lost flags |
| resync_cmd | input | 1 | Single-core resync strobe |
| resync_tgt | input | IW | Index of the core to resync |
| rd_val | output | NCORE*TW | Registered read ports, core i at bits i*TW upward |
| core_valid | output | NCORE | Per-core valid flags |

## Verification
A corrupted counter or a wrong read-select inside this block shows at the ports as one read port disagreeing with the others. This appears on the cycle after the fault, because every port carries the same one-cycle delay. A wrong valid flag appears at once on `core_valid`. An invalid core whose counter was zeroed but whose read was not redirected shows as a value lower than the reference, one cycle after the next tick. A resync that copies without the concurrent tick leaves the resynced core exactly one count behind. That gap persists, so every later cycle exposes it.

// File: rtl/tbsync_pkg.sv
package tbsync_pkg;
  // Per-core operation decoded from the global command inputs.
  typedef struct packed {
    logic load;
    logic resync;
    logic lost;
  } core_op_t;
endpackage

// File: rtl/tbsync_op_decode.sv
module tbsync_op_decode
  import tbsync_pkg::*;
#(
  parameter int NCORE    = 4,
  parameter int REF_CORE = 0,
  parameter int IW       = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                       load_cmd,
  input  logic [NCORE-1:0]           lost,
  input  logic                       resync_cmd,
  input  logic [IW-1:0]              resync_tgt,
  output core_op_t [NCORE-1:0]       ops
);
  for (genvar i = 0; i < NCORE; i++) begin : g_op
    if (i == REF_CORE) begin : g_ref
      // reference core: authoritative, never lost, never resynced
      assign ops[i].load   = load_cmd;
      assign ops[i].resync = 1'b0;
      assign ops[i].lost   = 1'b0;
    end else begin : g_oth
      assign ops[i].load   = load_cmd;
      assign ops[i].resync = resync_cmd && (resync_tgt == IW'(i));
      assign ops[i].lost   = lost[i];
    end
  end
endmodule

// File: rtl/tbsync_core_ctr.sv
module tbsync_core_ctr
  import tbsync_pkg::*;
#(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  core_op_t      op,
  input  logic [TW-1:0] load_val,
  input  logic [TW-1:0] ref_next,
  output logic [TW-1:0] cnt,
  output logic          valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      valid <= 1'b1;
    end else if (op.load) begin
      cnt   <= load_val;           // tick of this cycle dropped
      valid <= 1'b1;
    end else if (op.resync) begin
      cnt   <= ref_next;           // already includes this cycle's tick
      valid <= 1'b1;
    end else if (op.lost) begin
      cnt   <= '0;
      valid <= 1'b0;
    end else if (valid) begin
      cnt   <= cnt + TW'(tick_en);
    end
  end
endmodule

// File: rtl/tbsync_rd_stage.sv
module tbsync_rd_stage #(
  parameter int NCORE    = 4,
  parameter int TW       = 64,
  parameter int REF_CORE = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCORE*TW-1:0]   cnt_flat,
  input  logic [NCORE-1:0]      valid,
  output logic [NCORE*TW-1:0]   rd_val
);
  localparam int REF_LO = REF_CORE * TW;

  for (genvar i = 0; i < NCORE; i++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_val[i*TW +: TW] <= '0;
      end else if (valid[i]) begin
        rd_val[i*TW +: TW] <= cnt_flat[i*TW +: TW];
      end else begin
        rd_val[i*TW +: TW] <= cnt_flat[REF_LO +: TW];
      end
    end
  end
endmodule

// File: rtl/tbsync_top.sv
module tbsync_top
  import tbsync_pkg::*;
#(
  parameter int NCORE    = 4,
  parameter int TW       = 64,
  parameter int REF_CORE = 0,
  parameter int IW       = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_en,
  input  logic                  load_cmd,
  input  logic [TW-1:0]         load_val,
  input  logic [NCORE-1:0]      lost,
  input  logic                  resync_cmd,
  input  logic [IW-1:0]         resync_tgt,
  output logic [NCORE*TW-1:0]   rd_val,
  output logic [NCORE-1:0]      core_valid
);
  localparam int REF_LO = REF_CORE * TW;

  core_op_t [NCORE-1:0] ops;
  logic [NCORE*TW-1:0]  cnt_flat;
  logic [NCORE-1:0]     valid;
  logic [TW-1:0]        ref_next;

  tbsync_op_decode #(.NCORE(NCORE), .REF_CORE(REF_CORE), .IW(IW)) u_dec (
    .load_cmd   (load_cmd),
    .lost       (lost),
    .resync_cmd (resync_cmd),
    .resync_tgt (resync_tgt),
    .ops        (ops)
  );

  assign ref_next = cnt_flat[REF_LO +: TW] + TW'(tick_en);

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    tbsync_core_ctr #(.TW(TW)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .tick_en  (tick_en),
      .op       (ops[i]),
      .load_val (load_val),
      .ref_next (ref_next),
      .cnt      (cnt_flat[i*TW +: TW]),
      .valid    (valid[i])
    );
  end

  tbsync_rd_stage #(.NCORE(NCORE), .TW(TW), .REF_CORE(REF_CORE)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .cnt_flat (cnt_flat),
    .valid    (valid),
    .rd_val   (rd_val)
  );

  assign core_valid = valid;
endmodule

// File: rtl/tbsync_chk.sv
module tbsync_chk #(
  parameter int NCORE    = 4,
  parameter int TW       = 64,
  parameter int REF_CORE = 0,
  parameter int IW       = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tick_en,
  input logic                  load_cmd,
  input logic [TW-1:0]         load_val,
  input logic [NCORE-1:0]      lost,
  input logic                  resync_cmd,
  input logic [IW-1:0]         resync_tgt,
  input logic [NCORE*TW-1:0]   rd_val,
  input logic [NCORE-1:0]      core_valid
);
  localparam int REF_LO = REF_CORE * TW;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (core_valid == '1 && rd_val == '0));

  a_r3_load_valid: assert property (@(posedge clk) disable iff (rst)
    load_cmd |=> (core_valid == '1));

  a_r3_load_value: assert property (@(posedge clk) disable iff (rst)
    load_cmd |=> ##1 (rd_val[REF_LO +: TW] == $past(load_val, 2)));

  a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !load_cmd) |=> ##1
      (rd_val[REF_LO +: TW] == $past(rd_val[REF_LO +: TW]) + TW'(1)));

  a_r6_resync_valid: assert property (@(posedge clk) disable iff (rst)
    (resync_cmd && !load_cmd) |=> core_valid[$past(resync_tgt)]);

  a_r4_ref_always_valid: assert property (@(posedge clk) disable iff (rst)
    core_valid[REF_CORE]);

  for (genvar i = 0; i < NCORE; i++) begin : g_c
    a_r8_ports_agree: assert property (@(posedge clk) disable iff (rst)
      rd_val[i*TW +: TW] == rd_val[REF_LO +: TW]);
    if (i != REF_CORE) begin : g_nr
      a_r4_lost_clears: assert property (@(posedge clk) disable iff (rst)
        (lost[i] && !load_cmd && !(resync_cmd && resync_tgt == IW'(i)))
          |=> !core_valid[i]);
    end
  end
endmodule

bind tbsync_top tbsync_chk #(
  .NCORE(NCORE), .TW(TW), .REF_CORE(REF_CORE), .IW(IW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_en    (tick_en),
  .load_cmd   (load_cmd),
  .load_val   (load_val),
  .lost       (lost),
  .resync_cmd (resync_cmd),
  .resync_tgt (resync_tgt),
  .rd_val     (rd_val),
  .core_valid (core_valid)
);

// File: tb/sim_tbsync_top.sv
module sim_tbsync_top;
  localparam int N   = 4;
  localparam int W   = 64;
  localparam int REF = 0;
  localparam int IW  = 2;

  logic           clk = 1'b0;
  logic           rst;
  logic           tick_en;
  logic           load_cmd;
  logic [W-1:0]   load_val;
  logic [N-1:0]   lost;
  logic           resync_cmd;
  logic [IW-1:0]  resync_tgt;
  logic [N*W-1:0] rd_val;
  logic [N-1:0]   core_valid;

  always #5 clk = ~clk;

  tbsync_top #(.NCORE(N), .TW(W), .REF_CORE(REF), .IW(IW)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load_cmd(load_cmd),
    .load_val(load_val), .lost(lost), .resync_cmd(resync_cmd),
    .resync_tgt(resync_tgt), .rd_val(rd_val), .core_valid(core_valid)
  );

  int total = 0;
  int bad   = 0;
  logic [W-1:0] m;      // expected counter value after the last edge
  logic [W-1:0] m_old;  // expected counter value before the last edge
  logic [N-1:0] vm;     // expected valid flags

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_ports(input string why);
    for (int i = 0; i < N; i++) begin
      if (i == REF)
        chk($sformatf("%s R7 core%0d read", why, i), rd_val[i*W +: W], m_old);
      else if (!vm[i])
        chk($sformatf("%s R5 core%0d read", why, i), rd_val[i*W +: W], m_old);
      else
        chk($sformatf("%s R8 core%0d read", why, i), rd_val[i*W +: W], m_old);
    end
    chk($sformatf("%s valid flags", why), W'(core_valid), W'(vm));
  endtask

  task automatic step(input string why, input logic t, input logic ld,
                      input logic [W-1:0] lv, input logic [N-1:0] ls,
                      input logic rs, input logic [IW-1:0] tg);
    tick_en = t; load_cmd = ld; load_val = lv; lost = ls;
    resync_cmd = rs; resync_tgt = tg;
    @(posedge clk);
    m_old = m;
    if (ld) begin
      m  = lv;
      vm = '1;
    end else begin
      m = m + W'(t);
      for (int i = 0; i < N; i++) begin
        if (i != REF) begin
          if (rs && tg == IW'(i)) vm[i] = 1'b1;
          else if (ls[i])         vm[i] = 1'b0;
        end
      end
    end
    @(negedge clk);
    tick_en = 1'b0; load_cmd = 1'b0; lost = '0; resync_cmd = 1'b0;
    check_ports(why);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    rst = 1'b1; tick_en = 1'b0; load_cmd = 1'b0; load_val = '0;
    lost = '0; resync_cmd = 1'b0; resync_tgt = '0;
    m = '0; m_old = '0; vm = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state visible on every port
    check_ports("R1 reset");

    // R2: ticking and holding
    for (int k = 0; k < 5; k++) step("R2 tick", 1'b1, 1'b0, '0, '0, 1'b0, '0);
    step("R2 hold", 1'b0, 1'b0, '0, '0, 1'b0, '0);
    step("R2 hold", 1'b0, 1'b0, '0, '0, 1'b0, '0);

    // R3: load suppresses tick, then R2 wraparound
    step("R3 load", 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFD, '0, 1'b0, '0);
    for (int k = 0; k < 5; k++) step("R2 wrap", 1'b1, 1'b0, '0, '0, 1'b0, '0);

    // R4: core 2 lost, reference lost bit ignored
    step("R4 lost", 1'b1, 1'b0, '0, 4'b0101, 1'b0, '0);
    // R5: invalid core reads follow the reference while time advances
    for (int k = 0; k < 4; k++) step("R5 redirect", 1'b1, 1'b0, '0, '0, 1'b0, '0);

    // R6: resync core 2 with a concurrent tick
    step("R6 resync", 1'b1, 1'b0, '0, '0, 1'b1, 2'd2);
    for (int k = 0; k < 3; k++) step("R6 after", 1'b1, 1'b0, '0, '0, 1'b0, '0);
    // R6: resync wins over lost on the same core; other core still lost
    step("R6 vs lost", 1'b1, 1'b0, '0, 4'b1010, 1'b1, 2'd1);
    step("R6 target ref", 1'b1, 1'b0, '0, '0, 1'b1, 2'd0);
    step("R6 check", 1'b0, 1'b0, '0, '0, 1'b0, '0);

    // R3: load overrides lost and resync in the same cycle
    step("R3 priority", 1'b1, 1'b1, 64'h0000_0001_2345_6789, 4'b1110, 1'b1, 2'd3);
    step("R3 after", 1'b1, 1'b0, '0, '0, 1'b0, '0);
    step("R3 after", 1'b1, 1'b0, '0, '0, 1'b0, '0);

    // Near-exhaustive sweep over command combinations (R2..R8)
    for (int c = 0; c < 4000; c++) begin
      automatic logic          t  = (c % 3) != 0;
      automatic logic          ld = (c % 211) == 100;
      automatic logic [N-1:0]  ls = N'((c * 5) >> 2) & ((c % 4 == 1) ? 4'hF : 4'h0);
      automatic logic          rs = (c % 6) == 2;
      automatic logic [IW-1:0] tg = IW'(c / 6);
      automatic logic [W-1:0]  lv = {W{1'b1}} - W'(c * 3);
      step("R8 sweep", t, ld, lv, ls, rs, tg);
    end
    step("R7 drain", 1'b0, 1'b0, '0, '0, 1'b0, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule